// File: doc/BRIEF.md
# Transmit/Receive FIFO Pair with Level Triggers

This block sits between a serial shifter and the register bus of a serial peripheral. It holds two independent queues of eight entries each: a transmit queue that the bus fills and the shifter drains, and a receive queue that the shifter fills and the bus drains. Each entry is wide enough for a data word plus its control or tag bits. Both queues report occupancy flags and a 5-bit level, and both keep a sticky error flag for misuse.

Each queue has a programmable level trigger. The transmit trigger is a level condition that holds while the occupancy has drained down to the programmed value. The receive trigger is a flag that is evaluated only when an entry arrives. Four interrupt sources (transmit error, receive error, transmit level, receive level) have enable bits that are changed through separate set and clear strobes. They are masked and ORed with a pass-through peripheral interrupt into one request line. Each direction also has a DMA request.

All four data paths are valid/ready streams. The ready outputs are advisory. A write that ignores back-pressure is not stalled: it is refused and recorded in the error flag. Holding `rx_out_valid` high while `rx_out_ready` stays low is a peek. The head entry is visible and the queue does not change. Raising ready pops the entry.

Top module: `dual_fifo_trig`

## Requirements
- R1: Each queue holds DEPTH (8) entries. Its level output counts 0..8. `tx_empty` is 1 exactly when the transmit level is 0, and `tx_not_full` is 1 when it is below 8. `rx_not_empty` is 1 when the receive level is above 0, and `rx_full` is 1 when it equals 8.
- R2: Entries leave each queue in the order they were accepted. A push is accepted when valid and ready are both high. A pop happens when `*_out_valid` and `*_out_ready` are both high.
- R3: `tx_err` sets when the transmit queue is enabled and either of two things happens: a push is offered while the queue is full (the entry is discarded and the level stays 8), or `tx_out_ready` is high while the queue is empty. The flag is sticky. `err_clr[0]`=1 clears it, and a new error in the same cycle wins.
- R4: An entry offered to the receive queue while it is full is dropped, the stored entries are kept, and `rx_err` sets. `err_clr[1]`=1 clears `rx_err`.
- R5: A high `tx_flush` or `rx_flush` empties only that queue, with level 0 on the next cycle. A push in the same cycle is discarded, and a flush cycle raises no error.
- R6: While a queue's enable is low, it refuses pushes, shows ready=0 and valid=0, reports level 0 and empty, and raises no error. Its contents are discarded.
- R7: The transmit level source (interrupt bit 2) is active while `tx_en`, `tx_trig_en` and transmit level <= `tx_trig_lvl` all hold. A value of 0 means empty and 7 means no longer full.
- R8: The receive level source (interrupt bit 3) is set by an accepted arrival that brings the level to at least `rx_trig_lvl`+1 (0 means one entry, 7 means full). It stays set while the level remains at or above that value. Lowering `rx_trig_lvl` without a new arrival does not set it.
- R9: `tx_dma_req` = `tx_dma_en` and the transmit queue is enabled and not full. `rx_dma_req` = `rx_dma_en` and the receive queue is not empty.
- R10: `int_en` resets to 0. Bit order is 0 transmit error, 1 receive error, 2 transmit level, 3 receive level. A 1 on `int_en_set` sets the bit and a 1 on `int_en_clr` clears it. If both are 1 on the same bit, clear wins.
- R11: `int_status[3:0]` is each source ANDed with its enable bit, `int_status[4]` is `periph_int`, and `irq` is the OR of `int_status`.
- R12: While `rx_out_ready` is low, `rx_out_data` keeps showing the head entry and the level does not drop. One cycle with ready high advances to the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit queue enable |
| tx_flush | input | 1 | Empty transmit queue |
| tx_in_valid | input | 1 | Bus offers a transmit entry |
| tx_in_data | input | TX_W | Transmit entry |
| tx_in_ready | output | 1 | Transmit queue can accept |
| tx_out_valid | output | 1 | Transmit head available to shifter |
| tx_out_data | output | TX_W | Transmit head entry |
| tx_out_ready | input | 1 | Shifter takes transmit head |
| rx_en | input | 1 | Receive queue enable |
| rx_flush | input | 1 | Empty receive queue |
| rx_in_valid | input | 1 | Shifter delivers a receive entry |
| rx_in_data | input | RX_W | Receive entry |
| rx_in_ready | output | 1 | Receive queue can accept |
| rx_out_valid | output | 1 | Receive head available |
| rx_out_data | output | RX_W | Receive head entry (peek) |
| rx_out_ready | input | 1 | Pop receive head |
| tx_trig_en | input | 1 | Transmit level trigger enable |
| tx_trig_lvl | input | TRIG_W | Transmit trigger point |
| rx_trig_en | input | 1 | Receive level trigger enable |
| rx_trig_lvl | input | TRIG_W | Receive trigger point (minus one) |
| tx_dma_en | input | 1 | Transmit DMA mode |
| rx_dma_en | input | 1 | Receive DMA mode |
| err_clr | input | 2 | Clear strobes: bit 0 transmit, bit 1 receive error |
| int_en_set | input | 4 | Interrupt enable set strobes |
| int_en_clr | input | 4 | Interrupt enable clear strobes |
| periph_int | input | 1 | Peripheral interrupt pass-through |
| tx_empty | output | 1 | Transmit queue empty |
| tx_not_full | output | 1 | Transmit queue not full |
| rx_not_empty | output | 1 | Receive queue not empty |
| rx_full | output | 1 | Receive queue full |
| tx_level | output | LVL_W | Transmit occupancy |
| rx_level | output | LVL_W | Receive occupancy |
| tx_err | output | 1 | Sticky transmit error |
| rx_err | output | 1 | Sticky receive error |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| int_en | output | 4 | Interrupt enable bits |
| int_status | output | 5 | Masked sources plus peripheral bit |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: DEPTH 8, 28-bit transmit and 21-bit receive entries, 5-bit levels and 4-bit trigger points. With a depth of eight, the bench can fill both queues completely in a few cycles and can program every trigger value from empty to no-longer-full. That puts the full-queue overflow, the dropped receive arrival and the trigger comparisons at both ends of the range within reach. The wide entries let the bench push distinct tagged values and confirm ordering and peek contents.

// File: rtl/dft_pkg.sv
package dft_pkg;
  // interrupt source bit positions
  localparam int SRC_TXERR = 0;
  localparam int SRC_RXERR = 1;
  localparam int SRC_TXLVL = 2;
  localparam int SRC_RXLVL = 3;
  localparam int SRC_N     = 4;
endpackage

// File: rtl/dft_ring.sv
module dft_ring #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             push_ok,
  output logic             pop_ok
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             clr;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  assign clr     = flush | ~en;
  assign full    = (count == DEPTH_C);
  assign empty   = (count == '0);
  assign push_ok = en & ~flush & push & ~full;
  assign pop_ok  = en & ~flush & pop & ~empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (!push_ok && pop_ok) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end
endmodule

// File: rtl/dft_irq.sv
module dft_irq
  import dft_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src,
  input  logic [SRC_N-1:0] en_set,
  input  logic [SRC_N-1:0] en_clr,
  input  logic             periph_int,
  output logic [SRC_N-1:0] en_q,
  output logic [SRC_N:0]   status,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q | en_set) & ~en_clr;
  end

  assign status = {periph_int, src & en_q};
  assign irq    = |status;
endmodule

// File: rtl/dual_fifo_trig.sv
module dual_fifo_trig
  import dft_pkg::*;
#(
  parameter int  TX_W   = 28,
  parameter int  RX_W   = 21,
  parameter int  DEPTH  = 8,
  localparam int LVL_W  = $clog2(DEPTH + 1) + 1,
  localparam int TRIG_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              tx_flush,
  input  logic              tx_in_valid,
  input  logic [TX_W-1:0]   tx_in_data,
  output logic              tx_in_ready,
  output logic              tx_out_valid,
  output logic [TX_W-1:0]   tx_out_data,
  input  logic              tx_out_ready,
  input  logic              rx_en,
  input  logic              rx_flush,
  input  logic              rx_in_valid,
  input  logic [RX_W-1:0]   rx_in_data,
  output logic              rx_in_ready,
  output logic              rx_out_valid,
  output logic [RX_W-1:0]   rx_out_data,
  input  logic              rx_out_ready,
  input  logic              tx_trig_en,
  input  logic [TRIG_W-1:0] tx_trig_lvl,
  input  logic              rx_trig_en,
  input  logic [TRIG_W-1:0] rx_trig_lvl,
  input  logic              tx_dma_en,
  input  logic              rx_dma_en,
  input  logic [1:0]        err_clr,
  input  logic [3:0]        int_en_set,
  input  logic [3:0]        int_en_clr,
  input  logic              periph_int,
  output logic              tx_empty,
  output logic              tx_not_full,
  output logic              rx_not_empty,
  output logic              rx_full,
  output logic [LVL_W-1:0]  tx_level,
  output logic [LVL_W-1:0]  rx_level,
  output logic              tx_err,
  output logic              rx_err,
  output logic              tx_dma_req,
  output logic              rx_dma_req,
  output logic [3:0]        int_en,
  output logic [4:0]        int_status,
  output logic              irq
);
  logic [LVL_W-1:0] tx_cnt, rx_cnt, rx_cnt_nxt, rx_thr;
  logic tx_full_r, tx_empty_r, rx_full_r, rx_empty_r;
  logic tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic tx_ovf, tx_unf, rx_ovf;
  logic tx_lvl_src, rx_lvl_flag;
  logic [SRC_N-1:0] src;

  dft_ring #(.W(TX_W), .DEPTH(DEPTH), .CNT_W(LVL_W)) i_tx_ring (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .flush(tx_flush),
    .push(tx_in_valid), .pop(tx_out_ready), .din(tx_in_data),
    .dout(tx_out_data), .count(tx_cnt), .full(tx_full_r), .empty(tx_empty_r),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  dft_ring #(.W(RX_W), .DEPTH(DEPTH), .CNT_W(LVL_W)) i_rx_ring (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .flush(rx_flush),
    .push(rx_in_valid), .pop(rx_out_ready), .din(rx_in_data),
    .dout(rx_out_data), .count(rx_cnt), .full(rx_full_r), .empty(rx_empty_r),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  // stream handshakes and status, all forced to "empty" when disabled
  assign tx_in_ready  = tx_en & ~tx_full_r;
  assign tx_out_valid = tx_en & ~tx_empty_r;
  assign rx_in_ready  = rx_en & ~rx_full_r;
  assign rx_out_valid = rx_en & ~rx_empty_r;
  assign tx_level     = tx_en ? tx_cnt : '0;
  assign rx_level     = rx_en ? rx_cnt : '0;
  assign tx_empty     = ~tx_out_valid;
  assign tx_not_full  = ~tx_en | ~tx_full_r;
  assign rx_not_empty = rx_out_valid;
  assign rx_full      = rx_en & rx_full_r;

  // error detection: refused push, empty pop, dropped arrival
  assign tx_ovf = tx_en & ~tx_flush & tx_in_valid & tx_full_r;
  assign tx_unf = tx_en & ~tx_flush & tx_out_ready & tx_empty_r;
  assign rx_ovf = rx_en & ~rx_flush & rx_in_valid & rx_full_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_err <= 1'b0;
      rx_err <= 1'b0;
    end else begin
      tx_err <= (tx_err & ~err_clr[0]) | tx_ovf | tx_unf;
      rx_err <= (rx_err & ~err_clr[1]) | rx_ovf;
    end
  end

  // transmit trigger: plain level compare
  assign tx_lvl_src = tx_en & tx_trig_en & (tx_cnt <= LVL_W'(tx_trig_lvl));

  // receive trigger: armed only by an arrival, held while level stays high
  assign rx_thr = LVL_W'(rx_trig_lvl) + LVL_W'(1);

  always_comb begin
    rx_cnt_nxt = rx_cnt;
    if (rx_flush || !rx_en)         rx_cnt_nxt = '0;
    else if (rx_push_ok && !rx_pop_ok) rx_cnt_nxt = rx_cnt + 1'b1;
    else if (!rx_push_ok && rx_pop_ok) rx_cnt_nxt = rx_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_lvl_flag <= 1'b0;
    else        rx_lvl_flag <= rx_trig_en & (rx_cnt_nxt >= rx_thr)
                               & (rx_push_ok | rx_lvl_flag);
  end

  assign tx_dma_req = tx_dma_en & tx_in_ready;
  assign rx_dma_req = rx_dma_en & rx_out_valid;

  always_comb begin
    src            = '0;
    src[SRC_TXERR] = tx_err;
    src[SRC_RXERR] = rx_err;
    src[SRC_TXLVL] = tx_lvl_src;
    src[SRC_RXLVL] = rx_lvl_flag;
  end

  dft_irq i_irq (
    .clk(clk), .rst_n(rst_n), .src(src), .en_set(int_en_set),
    .en_clr(int_en_clr), .periph_int(periph_int),
    .en_q(int_en), .status(int_status), .irq(irq)
  );
endmodule

// File: rtl/dft_chk.sv
module dft_chk #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 5,
  parameter int RX_W  = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             tx_flush,
  input logic             tx_in_valid,
  input logic             tx_in_ready,
  input logic             tx_out_valid,
  input logic             tx_out_ready,
  input logic             tx_err,
  input logic [LVL_W-1:0] tx_cnt,
  input logic             rx_en,
  input logic             rx_flush,
  input logic             rx_in_valid,
  input logic             rx_full,
  input logic             rx_err,
  input logic             rx_out_valid,
  input logic             rx_out_ready,
  input logic [RX_W-1:0]  rx_out_data,
  input logic [LVL_W-1:0] rx_cnt
);
  localparam logic [LVL_W-1:0] FULL_C = LVL_W'(DEPTH);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= FULL_C) && (rx_cnt <= FULL_C)); // R1
  AST_TX_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !tx_flush && tx_in_valid && !tx_in_ready) |=> (tx_err && tx_cnt == FULL_C)); // R3
  AST_TX_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !tx_flush && tx_out_ready && !tx_out_valid) |=> tx_err); // R3
  AST_RX_DROP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !rx_flush && rx_in_valid && rx_full && !rx_out_ready) |=> (rx_err && rx_cnt == FULL_C)); // R4
  AST_TX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_cnt == '0)); // R5
  AST_RX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_cnt == '0)); // R5
  AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en || !rx_en) |=> ((tx_en || tx_cnt == '0) && (rx_en || rx_cnt == '0))); // R6
  AST_PEEK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !rx_flush && rx_out_valid && !rx_out_ready) |=> $stable(rx_out_data)); // R12
endmodule

bind dual_fifo_trig dft_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W), .RX_W(RX_W)) i_dft_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_flush(tx_flush),
  .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_out_valid(tx_out_valid),
  .tx_out_ready(tx_out_ready), .tx_err(tx_err), .tx_cnt(tx_cnt),
  .rx_en(rx_en), .rx_flush(rx_flush), .rx_in_valid(rx_in_valid), .rx_full(rx_full),
  .rx_err(rx_err), .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
  .rx_out_data(rx_out_data), .rx_cnt(rx_cnt)
);

// File: tb/test_dual_fifo_trig.sv
module test_dual_fifo_trig;
  localparam int TX_W = 28, RX_W = 21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, tx_flush = 0, tx_in_valid = 0, tx_out_ready = 0;
  logic [TX_W-1:0] tx_in_data = '0, tx_out_data;
  logic tx_in_ready, tx_out_valid;
  logic rx_en = 0, rx_flush = 0, rx_in_valid = 0, rx_out_ready = 0;
  logic [RX_W-1:0] rx_in_data = '0, rx_out_data;
  logic rx_in_ready, rx_out_valid;
  logic tx_trig_en = 0, rx_trig_en = 0;
  logic [3:0] tx_trig_lvl = '0, rx_trig_lvl = '0;
  logic tx_dma_en = 0, rx_dma_en = 0, periph_int = 0;
  logic [1:0] err_clr = '0;
  logic [3:0] int_en_set = '0, int_en_clr = '0, int_en;
  logic tx_empty, tx_not_full, rx_not_empty, rx_full, tx_err, rx_err;
  logic tx_dma_req, rx_dma_req, irq;
  logic [4:0] tx_level, rx_level, int_status;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  dual_fifo_trig i_dual_fifo_trig (.*);

  // {fill[3:0], trig[3:0], expect tx level bit, expect rx level bit}
  localparam logic [9:0] VEC [8] = '{
    10'b0000_0000_10, 10'b0001_0000_01, 10'b0011_0010_01, 10'b0011_0011_10,
    10'b0111_0111_10, 10'b1000_0111_01, 10'b1000_0000_01, 10'b0101_0110_10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic flush_both();
    tx_flush = 1; rx_flush = 1; tick(); tx_flush = 0; rx_flush = 0;
  endtask

  task automatic push_tx(input logic [TX_W-1:0] d);
    tx_in_valid = 1; tx_in_data = d; tick(); tx_in_valid = 0;
  endtask

  task automatic push_rx(input logic [RX_W-1:0] d);
    rx_in_valid = 1; rx_in_data = d; tick(); rx_in_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tx_en = 1; rx_en = 1;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // reset state
    chk("R1 reset tx_empty", tx_empty, 1);
    chk("R1 reset tx_not_full", tx_not_full, 1);
    chk("R1 reset rx_not_empty", rx_not_empty, 0);
    chk("R1 reset levels", {tx_level, rx_level}, 0);
    chk("R10 reset int_en", int_en, 0);
    chk("R11 reset irq", irq, 0);

    // vector table: trigger semantics across fill levels
    int_en_set = 4'b1100; tick(); int_en_set = '0;
    tx_trig_en = 1; rx_trig_en = 1;
    for (int v = 0; v < 8; v++) begin
      flush_both();
      tx_trig_lvl = VEC[v][5:2]; rx_trig_lvl = VEC[v][5:2];
      for (int i = 0; i < int'(VEC[v][9:6]); i++) begin
        tx_in_valid = 1; rx_in_valid = 1;
        tx_in_data = TX_W'(i); rx_in_data = RX_W'(i);
        tick();
      end
      tx_in_valid = 0; rx_in_valid = 0;
      chk("R1 level", {tx_level, rx_level}, {1'b0, VEC[v][9:6], 1'b0, VEC[v][9:6]});
      chk("R7 tx level trigger", int_status[2], VEC[v][1]);
      chk("R8 rx level trigger", int_status[3], VEC[v][0]);
    end
    // last vector left 5 entries in each queue
    chk("R1 partial flags", {tx_empty, tx_not_full, rx_not_empty, rx_full}, 4'b0110);

    // R8: lowering the trigger point without an arrival does not fire
    rx_trig_lvl = 0; tick();
    chk("R8 no fire without arrival", int_status[3], 0);
    push_rx(21'h55);
    chk("R8 fires on arrival", int_status[3], 1);
    tx_trig_en = 0; rx_trig_en = 0;
    int_en_clr = 4'b1100; tick(); int_en_clr = '0;

    // R2 ordering and R5 separate flush
    flush_both();
    push_tx(28'hA000001); push_tx(28'hA000002); push_tx(28'hA000003);
    push_rx(21'h1F001);
    tx_flush = 1; tick(); tx_flush = 0;
    chk("R5 tx flushed", tx_level, 0);
    chk("R5 rx untouched", rx_level, 1);
    push_tx(28'hB000001); push_tx(28'hB000002); push_tx(28'hB000003);
    for (int i = 1; i <= 3; i++) begin
      chk("R2 tx order", tx_out_data, 28'hB000000 + 28'(i));
      tx_out_ready = 1; tick(); tx_out_ready = 0;
    end
    chk("R2 drained", tx_empty, 1);

    // R3 overflow then underflow
    for (int i = 0; i < 8; i++) push_tx(28'hC000000 + 28'(i));
    chk("R3 full before", tx_in_ready, 0);
    push_tx(28'hFFFFFFF);
    chk("R3 overflow err", tx_err, 1);
    chk("R3 level kept", tx_level, 8);
    chk("R3 head kept", tx_out_data, 28'hC000000);
    err_clr = 2'b01; tick(); err_clr = '0;
    chk("R3 err cleared", tx_err, 0);
    tx_flush = 1; tx_out_ready = 1; tick(); tx_flush = 0;
    chk("R5 flush raises no error", tx_err, 0);
    tick(); tx_out_ready = 0;
    chk("R3 underflow err", tx_err, 1);
    err_clr = 2'b01; tick(); err_clr = '0;

    // R4 drop and R12 peek
    rx_flush = 1; tick(); rx_flush = 0;
    for (int i = 0; i < 8; i++) push_rx(21'h100 + 21'(i));
    chk("R1 rx full flag", rx_full, 1);
    push_rx(21'h1ABCD);
    chk("R4 rx err", rx_err, 1);
    chk("R4 level kept", rx_level, 8);
    tick(); tick();
    chk("R12 peek head", rx_out_data, 21'h100);
    chk("R12 peek level", rx_level, 8);
    rx_out_ready = 1; tick(); rx_out_ready = 0;
    chk("R12 pop advances", rx_out_data, 21'h101);
    chk("R12 pop level", rx_level, 7);
    for (int i = 2; i < 8; i++) begin
      rx_out_ready = 1; tick(); rx_out_ready = 0;
    end
    chk("R4 last kept entry", rx_out_data, 21'h107);
    err_clr = 2'b10; tick(); err_clr = '0;
    chk("R4 rx err cleared", rx_err, 0);

    // R9 DMA requests
    tx_dma_en = 1; rx_dma_en = 1; tick();
    chk("R9 tx dma not full", tx_dma_req, 1);
    chk("R9 rx dma not empty", rx_dma_req, 1);
    rx_out_ready = 1; tick(); rx_out_ready = 0;
    chk("R9 rx dma empty", rx_dma_req, 0);
    tx_flush = 1; tick(); tx_flush = 0;
    for (int i = 0; i < 8; i++) push_tx(28'(i));
    chk("R9 tx dma full", tx_dma_req, 0);
    tx_dma_en = 0; rx_dma_en = 0;

    // R6 disable
    tx_en = 0; tick();
    chk("R6 disabled level", tx_level, 0);
    chk("R6 disabled ready", {tx_in_ready, tx_out_valid}, 0);
    push_tx(28'h1234567);
    tx_out_ready = 1; tick(); tx_out_ready = 0;
    chk("R6 no error while disabled", tx_err, 0);
    tx_en = 1; tick();
    chk("R6 contents discarded", tx_level, 0);

    // R10 enable set/clear, R11 masking
    int_en_set = 4'b0011; tick(); int_en_set = '0;
    chk("R10 set", int_en, 4'b0011);
    int_en_set = 4'b0100; int_en_clr = 4'b0101; tick();
    int_en_set = '0; int_en_clr = '0;
    chk("R10 clear wins", int_en, 4'b0010);
    tx_out_ready = 1; tick(); tx_out_ready = 0; // empty pop -> tx_err
    chk("R11 masked tx err", {int_status, irq}, 6'b000000);
    periph_int = 1; tick();
    chk("R11 peripheral bit", {int_status, irq}, 6'b100001);
    periph_int = 0;
    int_en_set = 4'b0001; tick(); int_en_set = '0;
    chk("R11 unmasked tx err", {int_status, irq}, 6'b000011);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule